// File: doc/BRIEF.md
# Banked Paired Register File

This block stores the six byte-wide general registers of a small processor core, named B, C, D, E, H and L, in two complete banks. Only one bank is active at a time; a single-cycle swap command moves every register over to the other bank. The other bank keeps its contents until it becomes active again. The core can write any one register as a byte, or write one of the pairs BC, DE or HL as a 16-bit word. In each pair the first-named register is the high byte.

Loop and block-move instructions need some arithmetic on these registers, and the block does it without the ALU:
- It counts B down and reports whether B is still nonzero.
- It counts the 16-bit BC down and reports when BC reaches zero.
- It steps the DE and HL pointers up or down by one. These steps can happen in the same cycle as a BC countdown.

The active bank's BC, DE and HL values are always driven out for address generation. C is also driven out on its own as an I/O port number.

Top module: `gpr_bank_file`

## Requirements
- R1: While reset is held and immediately after it, every register in both banks is zero, the active bank index is 0, and both status flags are 0.
- R2: A byte write with byte_sel codes B=0, C=1, D=2, E=3, H=4, L=5 stores byte_wdata into that register of the active bank, visible on the outputs after the next rising edge. Codes 6 and 7 change nothing.
- R3: A pair write with pair_sel codes BC=0, DE=1, HL=2 stores pair_wdata into the active bank in one cycle. The upper byte goes to B, D or H and the lower byte to C, E or L. Code 3 changes nothing.
- R4: When a byte write and a pair write target the same register in one cycle, the pair data is stored. A byte write to a different register in that cycle still takes effect.
- R5: A swap_bank pulse advances the active bank after the next edge. Each bank retains its own contents across swaps, and bank_o shows the active index.
- R6: Writes, decrements and steps issued in the same cycle as a swap act on the bank that was active before the swap.
- R7: A b_dec pulse lowers B by one, wrapping from 0x00 to 0xFF, and leaves C unchanged. From the next edge on, b_nz_o is 1 exactly when the decremented B is nonzero.
- R8: A bc_dec pulse lowers the 16-bit BC by one, wrapping from 0x0000 to 0xFFFF. From the next edge on, bc_zero_o is 1 exactly when the decremented BC is zero.
- R9: de_step and hl_step use the codes 1 = increment, 2 = decrement, 0 and 3 = hold. The steps wrap modulo 65536 and can be issued together with bc_dec in the same cycle.
- R10: An explicit byte or pair write overrides a step or decrement for the bytes it targets. Other bytes of the stepped pair still take their stepped value. The flags still report the decremented value.
- R11: When b_dec and bc_dec are both asserted, only the BC decrement is performed and b_nz_o keeps its value.
- R12: bc_o, de_o, hl_o, io_port_o (equal to C) and byte_rdata (selected by byte_rsel with the R2 codes, zero for codes 6 and 7) reflect the active bank combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_we | input | 1 | Byte write enable |
| byte_sel | input | 3 | Byte write target (B=0 … L=5) |
| byte_wdata | input | DW | Byte write data |
| pair_we | input | 1 | Pair write enable |
| pair_sel | input | 2 | Pair write target (BC=0, DE=1, HL=2) |
| pair_wdata | input | 2*DW | Pair write data, high byte first register |
| swap_bank | input | 1 | Advance to the other register bank |
| b_dec | input | 1 | Decrement B |
| bc_dec | input | 1 | Decrement BC |
| de_step | input | 2 | DE pointer step code |
| hl_step | input | 2 | HL pointer step code |
| byte_rsel | input | 3 | Byte read select |
| byte_rdata | output | DW | Selected byte of the active bank |
| bc_o | output | 2*DW | Active BC pair |
| de_o | output | 2*DW | Active DE pair |
| hl_o | output | 2*DW | Active HL pair |
| io_port_o | output | DW | Active C register as I/O port number |
| bank_o | output | BANK_W | Active bank index |
| b_nz_o | output | 1 | Last B decrement left a nonzero value |
| bc_zero_o | output | 1 | Last BC decrement reached zero |

## Verification
Every state change is due one cycle after its command: stores, steps, decrements, swaps and both flags land at the rising edge that samples the request. The bench drives a command shortly after one edge, lets exactly one edge pass, and reads the outputs one nanosecond after that edge. A check therefore never looks at the value from before or two cycles after the command. The byte read port has no register, so it is checked a nanosecond after the select changes, with no edge in between. Collision cases use starting values chosen so that a wrong priority or a wrong flag source produces a different number.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   localparam int NUM_REGS = 6;

   localparam int IDX_B = 0;
   localparam int IDX_C = 1;
   localparam int IDX_D = 2;
   localparam int IDX_E = 3;
   localparam int IDX_H = 4;
   localparam int IDX_L = 5;

   typedef enum logic [1:0] {
      PAIR_BC   = 2'd0,
      PAIR_DE   = 2'd1,
      PAIR_HL   = 2'd2,
      PAIR_NONE = 2'd3
   } pair_sel_e;

   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_INC   = 2'd1,
      STEP_DEC   = 2'd2,
      STEP_HOLD2 = 2'd3
   } step_e;

endpackage

// File: rtl/gpr_stepper.sv
module gpr_stepper #(
   parameter int W       = 16,
   parameter bit HAS_INC = 1'b1
) (
   input  logic [W-1:0] val_i,
   input  logic [1:0]   op_i,
   output logic [W-1:0] val_o,
   output logic         active_o
);
   import gpr_pkg::*;

   initial begin
      if (W < 2) $error("gpr_stepper: W must be at least 2");
   end

   generate
      if (HAS_INC) begin : g_updown
         always_comb begin
            val_o    = val_i;
            active_o = 1'b0;
            case (op_i)
               STEP_INC: begin
                  val_o    = val_i + W'(1);
                  active_o = 1'b1;
               end
               STEP_DEC: begin
                  val_o    = val_i - W'(1);
                  active_o = 1'b1;
               end
               default: begin
                  val_o    = val_i;
                  active_o = 1'b0;
               end
            endcase
         end
      end else begin : g_down_only
         always_comb begin
            active_o = (op_i == STEP_DEC);
            val_o    = active_o ? (val_i - W'(1)) : val_i;
         end
      end
   endgenerate

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
   parameter int DW   = 8,
   parameter int NREG = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NREG-1:0]    we_i,
   input  logic [NREG*DW-1:0] wdata_i,
   output logic [NREG*DW-1:0] rdata_o
);

   initial begin
      if (DW < 1)   $error("gpr_bank: DW must be positive");
      if (NREG < 1) $error("gpr_bank: NREG must be positive");
   end

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (we_i[r]) q <= wdata_i[r*DW +: DW];
         end
         assign rdata_o[r*DW +: DW] = q;
      end
   endgenerate

   // R5: a bank with no write enable keeps every byte
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i == '0) |=> $stable(rdata_o));

endmodule

// File: rtl/gpr_bank_sel.sv
module gpr_bank_sel #(
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_i,
   output logic [BANK_W-1:0] bank_o
);

   initial begin
      if ((1 << BANK_W) != NUM_BANKS)
         $error("gpr_bank_sel: NUM_BANKS must equal 2**BANK_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bank_o <= '0;
      else if (swap_i) bank_o <= bank_o + BANK_W'(1);
   end

   p_swap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_i |=> $stable(bank_o));

endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file #(
   parameter int DW        = 8,
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_we,
   input  logic [2:0]        byte_sel,
   input  logic [DW-1:0]     byte_wdata,
   input  logic              pair_we,
   input  logic [1:0]        pair_sel,
   input  logic [2*DW-1:0]   pair_wdata,
   input  logic              swap_bank,
   input  logic              b_dec,
   input  logic              bc_dec,
   input  logic [1:0]        de_step,
   input  logic [1:0]        hl_step,
   input  logic [2:0]        byte_rsel,
   output logic [DW-1:0]     byte_rdata,
   output logic [2*DW-1:0]   bc_o,
   output logic [2*DW-1:0]   de_o,
   output logic [2*DW-1:0]   hl_o,
   output logic [DW-1:0]     io_port_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              b_nz_o,
   output logic              bc_zero_o
);
   import gpr_pkg::*;

   localparam int NREG  = NUM_REGS;
   localparam int NPAIR = NREG / 2;
   localparam int PW    = 2 * DW;
   localparam int FW    = NREG * DW;

   generate
      if (NUM_BANKS < 2) begin : g_err_banks
         initial $error("gpr_bank_file: NUM_BANKS must be at least 2");
      end
      if ((1 << BANK_W) != NUM_BANKS) begin : g_err_pow2
         initial $error("gpr_bank_file: NUM_BANKS must be a power of two");
      end
      if (DW < 2) begin : g_err_dw
         initial $error("gpr_bank_file: DW must be at least 2");
      end
   endgenerate

   // ---------------- bank select and storage ----------------
   logic [BANK_W-1:0] bank_q;
   logic [FW-1:0]     bank_rd [NUM_BANKS];
   logic [FW-1:0]     cur_flat;
   logic [DW-1:0]     cur [NREG];
   logic [DW-1:0]     nxt [NREG];
   logic [FW-1:0]     nxt_flat;
   logic [NREG-1:0]   reg_en;

   gpr_bank_sel #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .swap_i (swap_bank),
      .bank_o (bank_q)
   );

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
         logic [NREG-1:0] bank_we;
         assign bank_we = (bank_q == BANK_W'(k)) ? reg_en : '0;
         gpr_bank #(.DW(DW), .NREG(NREG)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bank_we),
            .wdata_i (nxt_flat),
            .rdata_o (bank_rd[k])
         );
      end
   endgenerate

   assign cur_flat = bank_rd[bank_q];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_unpack
         assign cur[r]               = cur_flat[r*DW +: DW];
         assign nxt_flat[r*DW +: DW] = nxt[r];
      end
   endgenerate

   logic [PW-1:0] bc_cur, de_cur, hl_cur;
   assign bc_cur = {cur[IDX_B], cur[IDX_C]};
   assign de_cur = {cur[IDX_D], cur[IDX_E]};
   assign hl_cur = {cur[IDX_H], cur[IDX_L]};

   // ---------------- arithmetic helpers ----------------
   logic [DW-1:0] b_next;
   logic [PW-1:0] bc_next, de_next, hl_next;
   logic          b_act, bc_act, de_act, hl_act;

   gpr_stepper #(.W(DW), .HAS_INC(1'b0)) u_b_cnt (
      .val_i    (cur[IDX_B]),
      .op_i     (b_dec ? STEP_DEC : STEP_HOLD),
      .val_o    (b_next),
      .active_o (b_act)
   );

   gpr_stepper #(.W(PW), .HAS_INC(1'b0)) u_bc_cnt (
      .val_i    (bc_cur),
      .op_i     (bc_dec ? STEP_DEC : STEP_HOLD),
      .val_o    (bc_next),
      .active_o (bc_act)
   );

   gpr_stepper #(.W(PW), .HAS_INC(1'b1)) u_de_ptr (
      .val_i    (de_cur),
      .op_i     (de_step),
      .val_o    (de_next),
      .active_o (de_act)
   );

   gpr_stepper #(.W(PW), .HAS_INC(1'b1)) u_hl_ptr (
      .val_i    (hl_cur),
      .op_i     (hl_step),
      .val_o    (hl_next),
      .active_o (hl_act)
   );

   // ---------------- next-value merge, lowest priority first ----------------
   always_comb begin
      for (int r = 0; r < NREG; r++) begin
         nxt[r]    = cur[r];
         reg_en[r] = 1'b0;
      end
      if (bc_act) begin
         nxt[IDX_B] = bc_next[PW-1:DW];
         nxt[IDX_C] = bc_next[DW-1:0];
         reg_en[IDX_B] = 1'b1;
         reg_en[IDX_C] = 1'b1;
      end else if (b_act) begin
         nxt[IDX_B]    = b_next;
         reg_en[IDX_B] = 1'b1;
      end
      if (de_act) begin
         nxt[IDX_D] = de_next[PW-1:DW];
         nxt[IDX_E] = de_next[DW-1:0];
         reg_en[IDX_D] = 1'b1;
         reg_en[IDX_E] = 1'b1;
      end
      if (hl_act) begin
         nxt[IDX_H] = hl_next[PW-1:DW];
         nxt[IDX_L] = hl_next[DW-1:0];
         reg_en[IDX_H] = 1'b1;
         reg_en[IDX_L] = 1'b1;
      end
      for (int r = 0; r < NREG; r++) begin
         if (byte_we && (byte_sel == 3'(r))) begin
            nxt[r]    = byte_wdata;
            reg_en[r] = 1'b1;
         end
      end
      for (int p = 0; p < NPAIR; p++) begin
         if (pair_we && (pair_sel == 2'(p))) begin
            nxt[2*p]      = pair_wdata[PW-1:DW];
            nxt[2*p+1]    = pair_wdata[DW-1:0];
            reg_en[2*p]   = 1'b1;
            reg_en[2*p+1] = 1'b1;
         end
      end
   end

   // ---------------- status flags ----------------
   logic b_nz_q, bc_zero_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_nz_q    <= 1'b0;
         bc_zero_q <= 1'b0;
      end else begin
         if (b_act && !bc_act) b_nz_q    <= (b_next != '0);
         if (bc_act)           bc_zero_q <= (bc_next == '0);
      end
   end

   // ---------------- read side ----------------
   always_comb begin
      byte_rdata = '0;
      for (int r = 0; r < NREG; r++) begin
         if (byte_rsel == 3'(r)) byte_rdata = cur[r];
      end
   end

   assign bc_o      = bc_cur;
   assign de_o      = de_cur;
   assign hl_o      = hl_cur;
   assign io_port_o = cur[IDX_C];
   assign bank_o    = bank_q;
   assign b_nz_o    = b_nz_q;
   assign bc_zero_o = bc_zero_q;

   // ---------------- assertions ----------------
   logic b_touched, de_touched, hl_touched;
   assign b_touched  = (byte_we && byte_sel == 3'(IDX_B)) ||
                       (pair_we && pair_sel == PAIR_BC);
   assign de_touched = (byte_we && (byte_sel == 3'(IDX_D) || byte_sel == 3'(IDX_E))) ||
                       (pair_we && pair_sel == PAIR_DE);
   assign hl_touched = (byte_we && (byte_sel == 3'(IDX_H) || byte_sel == 3'(IDX_L))) ||
                       (pair_we && pair_sel == PAIR_HL);

   p_swap_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      swap_bank |=> (bank_o != $past(bank_o)));

   p_pair_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_we && pair_sel == PAIR_HL && !swap_bank) |=> (hl_o == $past(pair_wdata)));

   p_b_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_dec && !bc_dec && !b_touched && !swap_bank) |=>
      (bc_o[PW-1:DW] == DW'($past(bc_o[PW-1:DW]) - DW'(1))));

   p_b_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_dec && !bc_dec) |=> (b_nz_o == ($past(bc_o[PW-1:DW]) != DW'(1))));

   p_bc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bc_dec |=> (bc_zero_o == ($past(bc_o) == PW'(1))));

   p_hl_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hl_step == STEP_INC && !hl_touched && !swap_bank) |=>
      (hl_o == PW'($past(hl_o) + PW'(1))));

   p_de_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (de_step == STEP_DEC && !de_touched && !swap_bank) |=>
      (de_o == PW'($past(de_o) - PW'(1))));

   p_collide_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (b_dec && bc_dec) |=> $stable(b_nz_o));

endmodule

// File: tb/tb_gpr_bank_file.sv
`timescale 1ns/1ps
module tb_gpr_bank_file;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        byte_we;
   logic [2:0]  byte_sel;
   logic [7:0]  byte_wdata;
   logic        pair_we;
   logic [1:0]  pair_sel;
   logic [15:0] pair_wdata;
   logic        swap_bank, b_dec, bc_dec;
   logic [1:0]  de_step, hl_step;
   logic [2:0]  byte_rsel;
   logic [7:0]  byte_rdata, io_port_o;
   logic [15:0] bc_o, de_o, hl_o;
   logic [0:0]  bank_o;
   logic        b_nz_o, bc_zero_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   gpr_bank_file dut (
      .clk(clk), .rst_n(rst_n),
      .byte_we(byte_we), .byte_sel(byte_sel), .byte_wdata(byte_wdata),
      .pair_we(pair_we), .pair_sel(pair_sel), .pair_wdata(pair_wdata),
      .swap_bank(swap_bank), .b_dec(b_dec), .bc_dec(bc_dec),
      .de_step(de_step), .hl_step(hl_step),
      .byte_rsel(byte_rsel), .byte_rdata(byte_rdata),
      .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .io_port_o(io_port_o),
      .bank_o(bank_o), .b_nz_o(b_nz_o), .bc_zero_o(bc_zero_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      byte_we = 0; byte_sel = 0; byte_wdata = 0;
      pair_we = 0; pair_sel = 0; pair_wdata = 0;
      swap_bank = 0; b_dec = 0; bc_dec = 0;
      de_step = 0; hl_step = 0;
   endtask

   // one edge passes; results are read 1 ns after it
   task automatic tick();
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic wr_byte(input logic [2:0] s, input logic [7:0] d);
      byte_we = 1; byte_sel = s; byte_wdata = d; tick();
   endtask

   task automatic wr_pair(input logic [1:0] s, input logic [15:0] d);
      pair_we = 1; pair_sel = s; pair_wdata = d; tick();
   endtask

   task automatic t_reset();
      chk("R1 bc", bc_o, 16'h0);
      chk("R1 de", de_o, 16'h0);
      chk("R1 hl", hl_o, 16'h0);
      chk("R1 bank", 16'(bank_o), 16'h0);
      chk("R1 flags", {14'h0, b_nz_o, bc_zero_o}, 16'h0);
   endtask

   task automatic t_byte_write();
      for (int i = 0; i < 6; i++) wr_byte(3'(i), 8'(8'h11 * (i + 1)));
      chk("R2 bc", bc_o, 16'h1122);
      chk("R2 de", de_o, 16'h3344);
      chk("R2 hl", hl_o, 16'h5566);
      chk("R12 port", 16'(io_port_o), 16'h0022);
      byte_rsel = 3'd4; #1;
      chk("R12 rdata H", 16'(byte_rdata), 16'h0055);
      byte_rsel = 3'd7; #1;
      chk("R12 rdata code7", 16'(byte_rdata), 16'h0000);
      wr_byte(3'd6, 8'hFF);
      chk("R2 code6 bc", bc_o, 16'h1122);
      chk("R2 code6 de", de_o, 16'h3344);
      chk("R2 code6 hl", hl_o, 16'h5566);
   endtask

   task automatic t_pair_write();
      wr_pair(2'd1, 16'hABCD);
      chk("R3 de", de_o, 16'hABCD);
      wr_pair(2'd3, 16'h9999);
      chk("R3 code3 bc", bc_o, 16'h1122);
      chk("R3 code3 de", de_o, 16'hABCD);
      chk("R3 code3 hl", hl_o, 16'h5566);
   endtask

   task automatic t_priority();
      pair_we = 1; pair_sel = 2'd2; pair_wdata = 16'h1234;
      byte_we = 1; byte_sel = 3'd4; byte_wdata = 8'hEE;
      tick();
      chk("R4 pair over byte", hl_o, 16'h1234);
      pair_we = 1; pair_sel = 2'd0; pair_wdata = 16'h0102;
      byte_we = 1; byte_sel = 3'd3; byte_wdata = 8'h77;
      tick();
      chk("R4 pair bc", bc_o, 16'h0102);
      chk("R4 other byte", de_o, 16'hAB77);
   endtask

   task automatic t_exchange();
      swap_bank = 1; tick();
      chk("R5 bank1", 16'(bank_o), 16'h1);
      chk("R5 alt bc empty", bc_o, 16'h0);
      chk("R5 alt hl empty", hl_o, 16'h0);
      wr_pair(2'd0, 16'hBEEF);
      chk("R5 alt bc", bc_o, 16'hBEEF);
      swap_bank = 1; tick();
      chk("R5 bank0", 16'(bank_o), 16'h0);
      chk("R5 main bc kept", bc_o, 16'h0102);
      chk("R5 main hl kept", hl_o, 16'h1234);
      swap_bank = 1; pair_we = 1; pair_sel = 2'd0; pair_wdata = 16'h5555;
      tick();
      chk("R6 alt untouched", bc_o, 16'hBEEF);
      swap_bank = 1; tick();
      chk("R6 old bank written", bc_o, 16'h5555);
   endtask

   task automatic t_b_count();
      wr_byte(3'd0, 8'h02);
      b_dec = 1; tick();
      chk("R7 b=1", bc_o, 16'h0155);
      chk("R7 nz=1", 16'(b_nz_o), 16'h1);
      b_dec = 1; tick();
      chk("R7 b=0", bc_o, 16'h0055);
      chk("R7 nz=0", 16'(b_nz_o), 16'h0);
      b_dec = 1; tick();
      chk("R7 wrap", bc_o, 16'hFF55);
      chk("R7 nz wrap", 16'(b_nz_o), 16'h1);
   endtask

   task automatic t_bc_count();
      wr_pair(2'd0, 16'h0001);
      wr_pair(2'd2, 16'hFFFF);
      wr_pair(2'd1, 16'h0000);
      bc_dec = 1; hl_step = 2'd1; de_step = 2'd2; tick();
      chk("R8 bc zero", bc_o, 16'h0000);
      chk("R8 flag set", 16'(bc_zero_o), 16'h1);
      chk("R9 hl inc wrap", hl_o, 16'h0000);
      chk("R9 de dec wrap", de_o, 16'hFFFF);
      bc_dec = 1; hl_step = 2'd3; tick();
      chk("R8 bc wrap", bc_o, 16'hFFFF);
      chk("R8 flag clear", 16'(bc_zero_o), 16'h0);
      chk("R9 code3 hold", hl_o, 16'h0000);
   endtask

   task automatic t_collisions();
      wr_byte(3'd0, 8'h01);
      b_dec = 1; tick();
      chk("R7 nz low", 16'(b_nz_o), 16'h0);
      wr_pair(2'd0, 16'h0300);
      b_dec = 1; bc_dec = 1; tick();
      chk("R11 bc only", bc_o, 16'h02FF);
      chk("R11 nz held", 16'(b_nz_o), 16'h0);
      wr_pair(2'd0, 16'h0001);
      bc_dec = 1; pair_we = 1; pair_sel = 2'd0; pair_wdata = 16'h1000; tick();
      chk("R10 write over dec", bc_o, 16'h1000);
      chk("R10 flag from dec", 16'(bc_zero_o), 16'h1);
      wr_pair(2'd2, 16'h12FF);
      hl_step = 2'd1; byte_we = 1; byte_sel = 3'd5; byte_wdata = 8'h40; tick();
      chk("R10 partial override", hl_o, 16'h1340);
   endtask

   initial begin
      idle();
      byte_rsel = 3'd0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_byte_write();
      t_pair_write();
      t_priority();
      t_exchange();
      t_b_count();
      t_bc_count();
      t_collisions();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule